// File: doc/BRIEF.md
# Indirect 64-bit register access bridge

This bridge lets a host that only has a 32-bit register port reach 64-bit registers inside an attached engine. The host sees a small window of registers:

- two 32-bit staging halves of a 64-bit value;
- a command register;
- a clear register;
- a status register;
- an interrupt slot.

A write to the command register starts exactly one indirect access on the internal 64-bit register bus. The command carries both the target address and the direction, so each access is started by one host write.

For a store, the host first loads both halves and then writes the command with its top bit set. The bridge then issues a 64-bit write of the staged value. For a fetch, the host writes the command with the top bit clear. The returned 64-bit value lands in the two halves, and the host reads them afterwards.

The status register holds a sticky error flag. It is set by an error response or by an access that does not finish within a fixed number of cycles. A host should read status after every command. That read stalls until the access has finished.

The host port is a valid/ready request channel with a one-cycle read return pulse. The bridge drops ready while an internal access is outstanding, and the host must hold its request until ready is seen. The clear register is the only exception. A write to it is always accepted, and it aborts the access. The engine side is a valid/ready request channel plus an always-accepted response strobe. The bridge holds its request payload until the engine raises ready.

Top module: `reg64_bridge`

## Requirements
- R1: After reset, h_ready is 1, m_req_valid is 0, h_rvalid is 0, and the reads of offsets 0x00, 0x04 and 0x1C all return 0.
- R2: A host write to offset 0x00 sets bits 63:32 of the staged value, and a write to offset 0x04 sets bits 31:0. Reads of these offsets return them.
- R3: A host write to offset 0x08 with bit 31 = 1 raises m_req_valid in the next cycle. The request carries m_req_write = 1, m_req_addr = command bits 30:0 and m_req_wdata = {half 0x00, half 0x04}. The payload stays stable until m_req_ready is seen.
- R4: A command with bit 31 = 0 issues a read. An error-free response loads rdata[63:32] into offset 0x00 and rdata[31:0] into offset 0x04.
- R5: An error response sets status bit 31, and the flag stays set through later successful accesses. An erroring read leaves both halves unchanged.
- R6: If no response is accepted within TIMEOUT_CYCLES cycles of command acceptance, the access is abandoned and status bit 31 is set. A request stuck without ready is held for exactly TIMEOUT_CYCLES cycles.
- R7: A write of any value to offset 0x18 clears status bit 31 and aborts an outstanding access, so m_req_valid is 0 in the next cycle. This write is accepted even while busy.
- R8: While an access is outstanding, h_ready is 0 for every offset except 0x18.
- R9: An accepted host read returns h_rdata with a one-cycle h_rvalid pulse in the cycle after acceptance. Accepted writes give no h_rvalid.
- R10: Offset 0x20 and any unmapped offset read as 0, and writes to them change nothing. Status bits 30:0 read as 0.
- R11: A response strobe that arrives while no access awaits a response is ignored, both for the error flag and for the halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted this cycle when high with h_valid |
| h_addr | input | HADDR_W | Host byte offset |
| h_write | input | 1 | 1 = write, 0 = read |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read data strobe, one cycle after read acceptance |
| h_rdata | output | 32 | Host read data |
| m_req_valid | output | 1 | Internal request valid |
| m_req_ready | input | 1 | Engine accepts request |
| m_req_addr | output | IADDR_W | Internal register address |
| m_req_write | output | 1 | Internal request direction, 1 = write |
| m_req_wdata | output | 64 | Internal write data |
| m_rsp_valid | input | 1 | Engine response strobe |
| m_rsp_rdata | input | 64 | Engine read data |
| m_rsp_err | input | 1 | Engine error flag for this response |

## Verification
The engine model is varied along several axes:

- ready delays of zero and three cycles;
- response delays of one and two cycles;
- error responses;
- a request that is swallowed without a response;
- a ready held off past the timeout.

Together these separate a correct handshake from one that drops or re-issues the payload. They also separate a response-wait timeout from a request-wait timeout. A store is followed by a fetch of the same address after the halves have been overwritten with junk. This shows the halves really come from the response, and that the high and low halves are not swapped. Unwritten addresses return a computed pattern. The sequence also covers clears while busy, a stray response strobe, and accesses to the interrupt and unmapped offsets. These show that aborts, ignored strobes and dead offsets leave the flag and the halves untouched.

// File: rtl/reg64_bridge_pkg.sv
package reg64_bridge_pkg;
  localparam int HOST_W = 32;
  localparam int WIDE_W = 64;

  localparam logic [7:0] OFS_HI     = 8'h00;
  localparam logic [7:0] OFS_LO     = 8'h04;
  localparam logic [7:0] OFS_CMD    = 8'h08;
  localparam logic [7:0] OFS_CLEAR  = 8'h18;
  localparam logic [7:0] OFS_STATUS = 8'h1C;
  localparam logic [7:0] OFS_IRQ    = 8'h20;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_RSP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/reg64_errflag.sv
module reg64_errflag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  // clear has priority over a simultaneous set
  always_ff @(posedge clk) begin
    if (rst)        err_o <= 1'b0;
    else if (clr_i) err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
  end
endmodule

// File: rtl/reg64_seq.sv
module reg64_seq
  import reg64_bridge_pkg::*;
#(
  parameter int IADDR_W        = 31,
  parameter int TIMEOUT_CYCLES = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                start_write_i,
  input  logic [IADDR_W-1:0]  start_addr_i,
  input  logic [WIDE_W-1:0]   start_wdata_i,
  input  logic                abort_i,
  output logic                busy_o,
  output logic                fail_o,
  output logic                load_o,
  output logic                m_req_valid,
  input  logic                m_req_ready,
  output logic [IADDR_W-1:0]  m_req_addr,
  output logic                m_req_write,
  output logic [WIDE_W-1:0]   m_req_wdata,
  input  logic                m_rsp_valid,
  input  logic                m_rsp_err
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             got_rsp;
  logic             last_cyc;

  assign busy_o      = (state_q != SQ_IDLE);
  assign m_req_valid = (state_q == SQ_REQ);
  assign got_rsp     = (state_q == SQ_RSP) && m_rsp_valid;
  assign last_cyc    = (cnt_q == CNT_W'(TIMEOUT_CYCLES - 1));

  // a response wins over a timeout in the same cycle; an abort suppresses both
  assign fail_o = !abort_i && ((got_rsp && m_rsp_err) || (busy_o && !got_rsp && last_cyc));
  assign load_o = !abort_i && got_rsp && !m_rsp_err && !m_req_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      cnt_q       <= '0;
      m_req_addr  <= '0;
      m_req_write <= 1'b0;
      m_req_wdata <= '0;
    end else if (abort_i) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q     <= SQ_REQ;
            cnt_q       <= '0;
            m_req_addr  <= start_addr_i;
            m_req_write <= start_write_i;
            m_req_wdata <= start_wdata_i;
          end
        end
        default: begin
          if (got_rsp || last_cyc) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
          end else begin
            if (state_q == SQ_REQ && m_req_ready) state_q <= SQ_RSP;
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/reg64_host.sv
module reg64_host
  import reg64_bridge_pkg::*;
#(
  parameter int HADDR_W = 6,
  parameter int IADDR_W = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                h_valid,
  output logic                h_ready,
  input  logic [HADDR_W-1:0]  h_addr,
  input  logic                h_write,
  input  logic [HOST_W-1:0]   h_wdata,
  output logic                h_rvalid,
  output logic [HOST_W-1:0]   h_rdata,
  input  logic                busy_i,
  input  logic                err_i,
  input  logic                load_i,
  input  logic [WIDE_W-1:0]   load_data_i,
  output logic                start_o,
  output logic                start_write_o,
  output logic [IADDR_W-1:0]  start_addr_o,
  output logic [WIDE_W-1:0]   stage_o,
  output logic                clear_o
);
  logic              acc;
  logic              hit_hi, hit_lo, hit_cmd, hit_clr, hit_sts;
  logic [HOST_W-1:0] half_hi_q, half_lo_q;
  logic [HOST_W-1:0] rd_mux;

  assign hit_hi  = (h_addr == HADDR_W'(OFS_HI));
  assign hit_lo  = (h_addr == HADDR_W'(OFS_LO));
  assign hit_cmd = (h_addr == HADDR_W'(OFS_CMD));
  assign hit_clr = (h_addr == HADDR_W'(OFS_CLEAR));
  assign hit_sts = (h_addr == HADDR_W'(OFS_STATUS));

  assign h_ready = !busy_i || hit_clr;
  assign acc     = h_valid && h_ready;

  assign start_o       = acc && h_write && hit_cmd;
  assign start_write_o = h_wdata[HOST_W-1];
  assign start_addr_o  = h_wdata[IADDR_W-1:0];
  assign clear_o       = acc && h_write && hit_clr;
  assign stage_o       = {half_hi_q, half_lo_q};

  // interrupt slot and unmapped offsets fall through to zero
  always_comb begin
    rd_mux = '0;
    if (hit_hi)       rd_mux = half_hi_q;
    else if (hit_lo)  rd_mux = half_lo_q;
    else if (hit_sts) rd_mux = {err_i, {(HOST_W-1){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_hi_q <= '0;
      half_lo_q <= '0;
      h_rvalid  <= 1'b0;
      h_rdata   <= '0;
    end else begin
      if (load_i) begin
        half_hi_q <= load_data_i[WIDE_W-1:HOST_W];
        half_lo_q <= load_data_i[HOST_W-1:0];
      end else if (acc && h_write) begin
        if (hit_hi) half_hi_q <= h_wdata;
        if (hit_lo) half_lo_q <= h_wdata;
      end
      h_rvalid <= acc && !h_write;
      if (acc && !h_write) h_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/reg64_bridge.sv
module reg64_bridge
  import reg64_bridge_pkg::*;
#(
  parameter int HADDR_W        = 6,
  parameter int IADDR_W        = 31,
  parameter int TIMEOUT_CYCLES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_valid,
  output logic               h_ready,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic               h_write,
  input  logic [31:0]        h_wdata,
  output logic               h_rvalid,
  output logic [31:0]        h_rdata,
  output logic               m_req_valid,
  input  logic               m_req_ready,
  output logic [IADDR_W-1:0] m_req_addr,
  output logic               m_req_write,
  output logic [63:0]        m_req_wdata,
  input  logic               m_rsp_valid,
  input  logic [63:0]        m_rsp_rdata,
  input  logic               m_rsp_err
);
  logic               seq_busy;
  logic               seq_fail;
  logic               seq_load;
  logic               err_flag;
  logic               cmd_start;
  logic               cmd_write;
  logic [IADDR_W-1:0] cmd_addr;
  logic [WIDE_W-1:0]  stage;
  logic               clear;

  reg64_host #(.HADDR_W(HADDR_W), .IADDR_W(IADDR_W)) u_host (
    .clk(clk), .rst(rst),
    .h_valid(h_valid), .h_ready(h_ready), .h_addr(h_addr), .h_write(h_write),
    .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .busy_i(seq_busy), .err_i(err_flag), .load_i(seq_load), .load_data_i(m_rsp_rdata),
    .start_o(cmd_start), .start_write_o(cmd_write), .start_addr_o(cmd_addr),
    .stage_o(stage), .clear_o(clear)
  );

  reg64_seq #(.IADDR_W(IADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk(clk), .rst(rst),
    .start_i(cmd_start), .start_write_i(cmd_write), .start_addr_i(cmd_addr),
    .start_wdata_i(stage), .abort_i(clear),
    .busy_o(seq_busy), .fail_o(seq_fail), .load_o(seq_load),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_write(m_req_write), .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err)
  );

  reg64_errflag u_err (
    .clk(clk), .rst(rst), .set_i(seq_fail), .clr_i(clear), .err_o(err_flag)
  );
endmodule

// File: rtl/reg64_bridge_chk.sv
module reg64_bridge_chk
  import reg64_bridge_pkg::*;
#(
  parameter int HADDR_W        = 6,
  parameter int IADDR_W        = 31,
  parameter int TIMEOUT_CYCLES = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               h_valid,
  input logic               h_ready,
  input logic [HADDR_W-1:0] h_addr,
  input logic               h_write,
  input logic               h_rvalid,
  input logic               m_req_valid,
  input logic               m_req_ready,
  input logic [IADDR_W-1:0] m_req_addr,
  input logic               m_req_write,
  input logic [63:0]        m_req_wdata,
  input logic               busy
);
  localparam int RUN_W = $clog2(TIMEOUT_CYCLES + 2);
  logic [RUN_W-1:0] busy_run;
  logic             clr_hit;

  assign clr_hit = (h_addr == HADDR_W'(OFS_CLEAR));

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_payload_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (m_req_valid && !m_req_ready) |=>
      ($stable(m_req_addr) && $stable(m_req_write) && $stable(m_req_wdata)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    m_req_valid |-> (!h_ready || clr_hit));

  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_ready && h_write && clr_hit) |=> !m_req_valid);

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
    h_rvalid |-> $past(h_valid && h_ready && !h_write));

  assert_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RUN_W'(TIMEOUT_CYCLES));
endmodule

bind reg64_bridge reg64_bridge_chk #(
  .HADDR_W(HADDR_W), .IADDR_W(IADDR_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready), .h_addr(h_addr),
  .h_write(h_write), .h_rvalid(h_rvalid), .m_req_valid(m_req_valid),
  .m_req_ready(m_req_ready), .m_req_addr(m_req_addr), .m_req_write(m_req_write),
  .m_req_wdata(m_req_wdata), .busy(seq_busy)
);

// File: tb/tb_reg64_bridge.sv
`timescale 1ns/1ps
module tb_reg64_bridge;
  localparam int HAW = 6;
  localparam int IAW = 31;
  localparam int TO  = 32;

  logic clk = 0;
  logic rst = 1;
  logic h_valid = 0, h_write = 0;
  logic [HAW-1:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic h_ready, h_rvalid;
  logic [31:0] h_rdata;
  logic m_req_valid, m_req_write;
  logic m_req_ready = 0;
  logic [IAW-1:0] m_req_addr;
  logic [63:0] m_req_wdata;
  logic m_rsp_valid = 0, m_rsp_err = 0;
  logic [63:0] m_rsp_rdata = '0;

  always #5 clk = ~clk;

  reg64_bridge #(.HADDR_W(HAW), .IADDR_W(IAW), .TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready), .h_addr(h_addr),
    .h_write(h_write), .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_write(m_req_write), .m_req_wdata(m_req_wdata), .m_rsp_valid(m_rsp_valid),
    .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- engine model ----------------
  logic [63:0] mem [int];
  int eng_rdy_dly = 0, eng_rsp_dly = 1;
  bit eng_err = 0, eng_silent = 0, eng_stray = 0;
  bit e_pend = 0, e_wr = 0;
  int e_pcnt = 0, e_rcnt = 0;
  int e_addr = 0;
  logic [63:0] e_wd = '0;
  bit n_rsp, n_err;
  logic [63:0] n_data;

  function automatic logic [63:0] eng_read(input int a);
    if (mem.exists(a)) return mem[a];
    return {16'hC0DE, a[15:0], ~a};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_pend = 0; e_rcnt = 0;
      #1; m_req_ready = 0; m_rsp_valid = 0; m_rsp_err = 0; m_rsp_rdata = '0;
    end else begin
      n_rsp = 0; n_err = 0; n_data = '0;
      if (m_req_valid && m_req_ready) begin
        e_pend = 1; e_pcnt = eng_rsp_dly; e_addr = int'(m_req_addr);
        e_wr = m_req_write; e_wd = m_req_wdata; e_rcnt = 0;
      end else if (e_pend) begin
        if (eng_silent) e_pend = 0;
        else if (e_pcnt <= 1) begin
          n_rsp = 1; n_err = eng_err;
          n_data = e_wr ? 64'd0 : eng_read(e_addr);
          if (e_wr && !eng_err) mem[e_addr] = e_wd;
          e_pend = 0;
        end else e_pcnt--;
      end else if (m_req_valid && !m_req_ready) e_rcnt++;
      if (eng_stray) begin n_rsp = 1; n_err = 1; n_data = '1; eng_stray = 0; end
      #1;
      m_rsp_valid = n_rsp; m_rsp_err = n_err; m_rsp_rdata = n_data;
      m_req_ready = !e_pend && (e_rcnt >= eng_rdy_dly);
    end
  end

  // ---------------- cycle reference model ----------------
  int ms = 0, mc = 0;
  logic [31:0] r_hi = 0, r_lo = 0, r_rd = 0;
  bit r_err = 0, r_rv = 0, r_wr = 0;
  logic [IAW-1:0] r_addr = '0;
  logic [63:0] r_wd = '0;
  bit m_acc, m_clr;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mc = 0; r_hi = 0; r_lo = 0; r_err = 0; r_rv = 0; r_rd = 0;
    end else begin
      m_acc = h_valid && (ms == 0 || h_addr == 6'h18);
      m_clr = m_acc && h_write && h_addr == 6'h18;
      r_rv = m_acc && !h_write;
      if (r_rv) begin
        case (h_addr)
          6'h00: r_rd = r_hi;
          6'h04: r_rd = r_lo;
          6'h1C: r_rd = {r_err, 31'd0};
          default: r_rd = 0;
        endcase
      end
      if (m_clr) begin
        r_err = 0; ms = 0; mc = 0;
      end else if (ms != 0) begin
        if (ms == 2 && m_rsp_valid) begin
          if (m_rsp_err) r_err = 1;
          else if (!r_wr) begin r_hi = m_rsp_rdata[63:32]; r_lo = m_rsp_rdata[31:0]; end
          ms = 0; mc = 0;
        end else if (mc == TO - 1) begin
          r_err = 1; ms = 0; mc = 0;
        end else begin
          if (ms == 1 && m_req_ready) ms = 2;
          mc++;
        end
      end else if (m_acc && h_write) begin
        case (h_addr)
          6'h00: r_hi = h_wdata;
          6'h04: r_lo = h_wdata;
          6'h08: begin ms = 1; mc = 0; r_addr = h_wdata[30:0]; r_wr = h_wdata[31]; r_wd = {r_hi, r_lo}; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(h_ready == (ms == 0 || h_addr == 6'h18), "R8 h_ready", 64'(h_ready), 64'(ms == 0 || h_addr == 6'h18));
      check(h_rvalid == r_rv, "R9 h_rvalid", 64'(h_rvalid), 64'(r_rv));
      if (r_rv) check(h_rdata == r_rd, "R9 h_rdata", 64'(h_rdata), 64'(r_rd));
      check(m_req_valid == (ms == 1), "R3 m_req_valid", 64'(m_req_valid), 64'(ms == 1));
      if (ms == 1) begin
        check(m_req_addr == r_addr && m_req_write == r_wr, "R3 m_req_addr/write",
              {31'd0, m_req_write, 1'b0, m_req_addr}, {31'd0, r_wr, 1'b0, r_addr});
        check(m_req_wdata == r_wd, "R3 m_req_wdata", m_req_wdata, r_wd);
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic host_acc(input bit wr, input logic [HAW-1:0] a, input logic [31:0] d, output logic [31:0] rd);
    bit got;
    @(posedge clk); #1;
    h_valid = 1; h_write = wr; h_addr = a; h_wdata = d;
    do begin @(posedge clk); got = h_ready; end while (!got);
    #1; h_valid = 0;
    rd = '0;
    if (!wr) begin
      @(negedge clk);
      check(h_rvalid == 1'b1, "R9 read strobe", 64'(h_rvalid), 64'd1);
      rd = h_rdata;
    end
  endtask

  task automatic hw(input logic [HAW-1:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    host_acc(1, a, d, dummy);
  endtask

  task automatic hr(input logic [HAW-1:0] a, output logic [31:0] d);
    host_acc(0, a, '0, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(h_ready && !m_req_valid && !h_rvalid, "R1 idle after reset",
          {61'd0, h_ready, m_req_valid, h_rvalid}, 64'd4);
    hr(6'h00, v); check(v == 0, "R1 half 0x00", 64'(v), 0);
    hr(6'h04, v); check(v == 0, "R1 half 0x04", 64'(v), 0);
    hr(6'h1C, v); check(v == 0, "R1 status", 64'(v), 0);

    // R2 staging halves
    hw(6'h00, 32'h11223344);
    @(negedge clk); check(!h_rvalid, "R9 no strobe on write", 64'(h_rvalid), 0);
    hw(6'h04, 32'h55667788);
    hr(6'h00, v); check(v == 32'h11223344, "R2 half 0x00", 64'(v), 64'h11223344);
    hr(6'h04, v); check(v == 32'h55667788, "R2 half 0x04", 64'(v), 64'h55667788);

    // R3 internal write with ready back-pressure
    eng_rdy_dly = 3; eng_rsp_dly = 2;
    hw(6'h08, 32'h80000012);
    hr(6'h1C, v); check(v == 0, "R3 status after write", 64'(v), 0);
    check(mem.exists(32'h12) && mem[32'h12] == 64'h1122334455667788, "R3 engine stored value",
          mem.exists(32'h12) ? mem[32'h12] : 64'hX, 64'h1122334455667788);

    // R4 internal read overwrites the halves
    eng_rdy_dly = 0; eng_rsp_dly = 1;
    hw(6'h00, 32'hDEADBEEF); hw(6'h04, 32'h0BADF00D);
    hw(6'h08, 32'h00000012);
    hr(6'h00, v); check(v == 32'h11223344, "R4 read high half", 64'(v), 64'h11223344);
    hr(6'h04, v); check(v == 32'h55667788, "R4 read low half", 64'(v), 64'h55667788);
    hw(6'h08, 32'h00000007);
    hr(6'h00, v); check(v == 32'hC0DE0007, "R4 pattern high", 64'(v), 64'hC0DE0007);
    hr(6'h04, v); check(v == 32'hFFFFFFF8, "R4 pattern low", 64'(v), 64'hFFFFFFF8);

    // R5 error response, sticky, halves unchanged
    eng_err = 1;
    hw(6'h08, 32'h00000012);
    hr(6'h1C, v); check(v == 32'h80000000, "R5 error set", 64'(v), 64'h80000000);
    hr(6'h00, v); check(v == 32'hC0DE0007, "R5 high unchanged", 64'(v), 64'hC0DE0007);
    hr(6'h04, v); check(v == 32'hFFFFFFF8, "R5 low unchanged", 64'(v), 64'hFFFFFFF8);
    eng_err = 0;
    hw(6'h08, 32'h80000033);
    hr(6'h1C, v); check(v == 32'h80000000, "R5 sticky", 64'(v), 64'h80000000);
    check(mem.exists(32'h33), "R5 later write still done", 64'(mem.exists(32'h33)), 1);

    // R7 clear
    hw(6'h18, 32'h0);
    hr(6'h1C, v); check(v == 0, "R7 clear flag", 64'(v), 0);

    // R6 timeout with ready held off, plus R8 stall probe
    eng_rdy_dly = 1000;
    hw(6'h08, 32'h80000040);
    n = 0;
    forever begin
      @(negedge clk);
      if (!m_req_valid) break;
      n++;
      if (n == 3) begin
        #2; h_addr = 6'h00; h_write = 1; h_wdata = 32'h0; h_valid = 1;
        #1; check(!h_ready, "R8 stall on data write", 64'(h_ready), 0);
        h_valid = 0;
      end
    end
    check(n == TO, "R6 request held cycles", 64'(n), 64'(TO));
    hr(6'h1C, v); check(v == 32'h80000000, "R6 timeout flag", 64'(v), 64'h80000000);
    check(!mem.exists(32'h40), "R6 no store", 64'(mem.exists(32'h40)), 0);

    // R6 timeout waiting for a swallowed response
    hw(6'h18, 32'h0);
    eng_rdy_dly = 0; eng_silent = 1;
    hw(6'h08, 32'h00000005);
    hr(6'h1C, v); check(v == 32'h80000000, "R6 response timeout", 64'(v), 64'h80000000);

    // R7 abort while waiting for response and while requesting
    hw(6'h18, 32'h0);
    hw(6'h08, 32'h00000005);
    repeat (3) @(posedge clk);
    hw(6'h18, 32'h0);
    @(negedge clk); check(h_ready, "R7 idle after abort", 64'(h_ready), 1);
    eng_silent = 0; eng_rdy_dly = 1000;
    hw(6'h08, 32'h80000041);
    repeat (2) @(posedge clk);
    hw(6'h18, 32'h0);
    @(negedge clk); check(!m_req_valid, "R7 request dropped", 64'(m_req_valid), 0);
    hr(6'h1C, v); check(v == 0, "R7 no error after abort", 64'(v), 0);
    check(!mem.exists(32'h41), "R7 aborted store", 64'(mem.exists(32'h41)), 0);
    eng_rdy_dly = 0;

    // R10 dead offsets
    hw(6'h20, 32'hFFFFFFFF);
    hw(6'h0C, 32'hFFFFFFFF);
    hr(6'h20, v); check(v == 0, "R10 irq slot", 64'(v), 0);
    hr(6'h0C, v); check(v == 0, "R10 unmapped 0x0C", 64'(v), 0);
    hr(6'h3C, v); check(v == 0, "R10 unmapped 0x3C", 64'(v), 0);
    hr(6'h00, v); check(v == 32'hC0DE0007, "R10 halves intact", 64'(v), 64'hC0DE0007);
    hr(6'h1C, v); check(v == 0, "R10 status low bits", 64'(v), 0);

    // R11 stray response while idle
    @(negedge clk); eng_stray = 1;
    repeat (4) @(posedge clk);
    hr(6'h1C, v); check(v == 0, "R11 stray no error", 64'(v), 0);
    hr(6'h04, v); check(v == 32'hFFFFFFF8, "R11 stray no load", 64'(v), 64'hFFFFFFF8);

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule